// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address. It reads a four-level table of 64-bit entries, starting from a base register. It works one walk at a time. A one-cycle start pulse latches the virtual address, the base register, the no-execute enable and the access kind (load or store). The walker then reads one entry per level through a memory port that has a single outstanding request. At each level it checks the present bit and the reserved bits. Leaf pages of 1 GB, 2 MB and 4 KB are recognised. The walker ends with a one-cycle done pulse that carries either a translation or a fault class.

Accessed and dirty bits are updated with 32-bit compare-and-swap requests on the same port. The response flag `mrsp_ok_i` tells the walker whether the swap took effect. A failed swap on an intermediate entry makes the walker read that entry again. A failed swap on the leaf sends the walk back to the root. The translation carries the merged user, write and no-execute rights of every level on the path. Leaves that are 2 MB or larger end the walk early. A TLB or a fill engine can use the block as its miss handler.

Top module: `pt_walker`

## Requirements
- R1: The first entry is read at the base register with bits 11:0 cleared. Every later read is at the previous entry's frame bits (PA_W-1:12), with bits 11:3 set to the level's index and bits 2:0 set to zero. From the top level down, the indices are virtual address bits 47:39, 38:30, 29:21 and 20:12.
- R2: An entry whose bit 0 is clear ends the walk with `fault_kind_o` = 1 (not present). No further request is issued.
- R3: An entry ends the walk with `fault_kind_o` = 2 (reserved) if any of these holds:
  - a bit in 51:PA_W is set;
  - bit 63 is set while `nx_en_i` was low at start;
  - bit 7 is set in the top-level entry.
- R4: Bit 7 set in a second-level entry gives a 1 GB page (`page_size_o` = 2). Bit 7 set in a third-level entry gives a 2 MB page (`page_size_o` = 1). Otherwise the fourth-level entry gives a 4 KB page (`page_size_o` = 0). In a fourth-level entry, bit 7 has no meaning.
- R5: A 1 GB leaf with any of bits 29:13 set raises `fault_kind_o` = 2, and so does a 2 MB leaf with any of bits 20:13 set. Bit 12 of a large leaf is ignored.
- R6: In a non-leaf entry whose bit 5 (accessed) is clear, the walker sets bit 5 with a compare-and-swap:
  - `mreq_cmp_o` is the low 32 bits as read;
  - `mreq_swap_o` is the same value with bit 5 set;
  - if the swap fails, the same entry is read again.
- R7: At the leaf, bit 5 must be set, and for a store bit 6 (dirty) must be set as well. A compare-and-swap is issued only when one of these bits is clear. If that swap fails, the walk starts again from the base register.
- R8: `user_o` is the AND of bit 2 over every entry on the path. `write_o` is the AND of bit 1. `nx_o` is the OR of bit 63.
- R9: `paddr_o` is the leaf's frame, with the bits below the page size taken from the virtual address.
- R10: A request holds `mreq_valid_o` and its fields stable until `mreq_ready_i`. No new request is raised before the response to the previous one.
- R11: After reset `busy_o`, `done_o` and `mreq_valid_o` are low. `done_o` is a single-cycle pulse. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a walk (taken only when idle) |
| vaddr_i | input | 48 | Virtual address to translate |
| root_i | input | 64 | Table base register |
| nx_en_i | input | 1 | No-execute enable; when low, bit 63 is reserved |
| store_i | input | 1 | Access is a store (dirty bit is set at the leaf) |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_kind_o | output | 2 | 0 none, 1 not present, 2 reserved bit |
| paddr_o | output | PA_W | Physical address |
| page_size_o | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| user_o | output | 1 | Merged user permission |
| write_o | output | 1 | Merged write permission |
| nx_o | output | 1 | Merged no-execute |
| mreq_valid_o | output | 1 | Memory request valid |
| mreq_ready_i | input | 1 | Memory request accepted |
| mreq_cas_o | output | 1 | 0 = 64-bit read, 1 = 32-bit compare-and-swap |
| mreq_addr_o | output | PA_W | Entry address |
| mreq_cmp_o | output | 32 | Expected low word for the swap |
| mreq_swap_o | output | 32 | New low word for the swap |
| mrsp_valid_i | input | 1 | Response valid |
| mrsp_data_i | input | 64 | Read data |
| mrsp_ok_i | input | 1 | Swap took effect |

## Verification
The bench builds the walker with PA_W = 36. At that width the reserved band above the physical width (bits 51:36) can be reached with a single set bit, while all tables and pages still fit in a small sparse memory. The memory model alternates ready stalls and response delays. It can fail one chosen compare-and-swap, which exercises both the same-level retry and the restart from the root. A behavioural walk over a shadow copy of memory predicts every request and the final result.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_CAS_REQ, S_CAS_WAIT, S_DONE
  } walk_state_e;

  localparam logic [1:0] FK_NONE   = 2'd0;
  localparam logic [1:0] FK_ABSENT = 2'd1;
  localparam logic [1:0] FK_RSVD   = 2'd2;

  localparam logic [1:0] SZ_4K = 2'd0;
  localparam logic [1:0] SZ_2M = 2'd1;
  localparam logic [1:0] SZ_1G = 2'd2;

  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_ACCESS  = 5;
  localparam int BIT_DIRTY   = 6;
  localparam int BIT_LARGE   = 7;
  localparam int BIT_NOEXEC  = 63;
endpackage

// File: rtl/pw_entry_eval.sv
module pw_entry_eval #(
  parameter int PA_W = 46
) (
  input  logic [63:0] ent,
  input  logic [1:0]  lvl,
  input  logic        nx_en,
  output logic        present,
  output logic        rsvd,
  output logic        leaf,
  output logic [1:0]  size
);
  import pw_pkg::*;

  logic hi_rsvd;
  logic big1g, big2m;
  logic unused_bits;

  generate
    if (PA_W < 52) begin : g_hi
      assign hi_rsvd = |ent[51:PA_W];
    end else begin : g_nohi
      assign hi_rsvd = 1'b0;
    end
  endgenerate

  assign present = ent[BIT_PRESENT];
  assign big1g   = ent[BIT_LARGE] && (lvl == 2'd2);
  assign big2m   = ent[BIT_LARGE] && (lvl == 2'd1);
  assign leaf    = (lvl == 2'd0) || big1g || big2m;
  assign size    = big1g ? SZ_1G : (big2m ? SZ_2M : SZ_4K);

  always_comb begin
    rsvd = hi_rsvd;
    if (!nx_en && ent[BIT_NOEXEC])           rsvd = 1'b1;
    if ((lvl == 2'd3) && ent[BIT_LARGE])     rsvd = 1'b1;
    if (big1g && (|ent[29:13]))              rsvd = 1'b1;
    if (big2m && (|ent[20:13]))              rsvd = 1'b1;
  end

  assign unused_bits = ^{ent[62:52], ent[PA_W-1:30], ent[12:8], ent[6:1]};
endmodule

// File: rtl/pw_perm_acc.sv
module pw_perm_acc (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic acc,
  input  logic u_in,
  input  logic w_in,
  input  logic x_in,
  output logic u_q,
  output logic w_q,
  output logic x_q
);
  logic u_d, w_d, x_d;

  always_comb begin
    u_d = u_q;
    w_d = w_q;
    x_d = x_q;
    if (clr) begin
      u_d = 1'b1;
      w_d = 1'b1;
      x_d = 1'b0;
    end else if (acc) begin
      u_d = u_q & u_in;
      w_d = w_q & w_in;
      x_d = x_q | x_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_q <= 1'b0;
      w_q <= 1'b0;
      x_q <= 1'b0;
    end else if (clr || acc) begin
      u_q <= u_d;
      w_q <= w_d;
      x_q <= x_d;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W = 46
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [47:0]     vaddr_i,
  input  logic [63:0]     root_i,
  input  logic            nx_en_i,
  input  logic            store_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [1:0]      fault_kind_o,
  output logic [PA_W-1:0] paddr_o,
  output logic [1:0]      page_size_o,
  output logic            user_o,
  output logic            write_o,
  output logic            nx_o,
  output logic            mreq_valid_o,
  input  logic            mreq_ready_i,
  output logic            mreq_cas_o,
  output logic [PA_W-1:0] mreq_addr_o,
  output logic [31:0]     mreq_cmp_o,
  output logic [31:0]     mreq_swap_o,
  input  logic            mrsp_valid_i,
  input  logic [63:0]     mrsp_data_i,
  input  logic            mrsp_ok_i
);
  import pw_pkg::*;

  localparam int FRM_W = PA_W - 12;

  walk_state_e st_q, st_d;
  logic [1:0]       lvl_q, lvl_d;
  logic [FRM_W-1:0] base_q, base_d, root_q;
  logic [47:0]      va_q;
  logic [63:0]      ent_q, ent_d;
  logic             store_q, nxen_q;
  logic [1:0]       fk_q, fk_d, sz_q, sz_d;
  logic [PA_W-1:0]  pa_q, pa_d;
  logic             take, adv, perm_clr, perm_acc;

  logic [63:0]      ent_sel;
  logic             ev_present, ev_rsvd, ev_leaf;
  logic [1:0]       ev_size;
  logic [31:0]      set_bits;
  logic             need_set;
  logic [8:0]       idx;
  logic [PA_W-1:0]  leaf_pa;
  logic             unused_root;

  assign take    = (st_q == S_IDLE) && start_i;
  assign ent_sel = (st_q == S_RD_WAIT) ? mrsp_data_i : ent_q;

  pw_entry_eval #(.PA_W(PA_W)) i_eval (
    .ent(ent_sel), .lvl(lvl_q), .nx_en(nxen_q),
    .present(ev_present), .rsvd(ev_rsvd), .leaf(ev_leaf), .size(ev_size)
  );

  pw_perm_acc i_perm (
    .clk(clk), .rst_n(rst_n), .clr(perm_clr), .acc(perm_acc),
    .u_in(ent_sel[BIT_USER]), .w_in(ent_sel[BIT_WRITE]), .x_in(ent_sel[BIT_NOEXEC]),
    .u_q(user_o), .w_q(write_o), .x_q(nx_o)
  );

  always_comb begin
    set_bits = 32'(1) << BIT_ACCESS;
    if (store_q && ev_leaf) set_bits = set_bits | (32'(1) << BIT_DIRTY);
  end
  assign need_set = |(set_bits & ~ent_sel[31:0]);

  always_comb begin
    case (lvl_q)
      2'd3:    idx = va_q[47:39];
      2'd2:    idx = va_q[38:30];
      2'd1:    idx = va_q[29:21];
      default: idx = va_q[20:12];
    endcase
  end

  always_comb begin
    case (ev_size)
      SZ_1G:   leaf_pa = {ent_sel[PA_W-1:30], va_q[29:0]};
      SZ_2M:   leaf_pa = {ent_sel[PA_W-1:21], va_q[20:0]};
      default: leaf_pa = {ent_sel[PA_W-1:12], va_q[11:0]};
    endcase
  end

  always_comb begin
    st_d     = st_q;
    lvl_d    = lvl_q;
    base_d   = base_q;
    ent_d    = ent_q;
    fk_d     = fk_q;
    sz_d     = sz_q;
    pa_d     = pa_q;
    adv      = 1'b0;
    perm_clr = 1'b0;
    case (st_q)
      S_IDLE: if (start_i) begin
        st_d     = S_RD_REQ;
        lvl_d    = 2'd3;
        base_d   = root_i[PA_W-1:12];
        fk_d     = FK_NONE;
        perm_clr = 1'b1;
      end
      S_RD_REQ:  if (mreq_ready_i) st_d = S_RD_WAIT;
      S_RD_WAIT: if (mrsp_valid_i) begin
        ent_d = mrsp_data_i;
        if (!ev_present) begin
          fk_d = FK_ABSENT;
          st_d = S_DONE;
        end else if (ev_rsvd) begin
          fk_d = FK_RSVD;
          st_d = S_DONE;
        end else if (need_set) begin
          st_d = S_CAS_REQ;
        end else begin
          adv = 1'b1;
        end
      end
      S_CAS_REQ: if (mreq_ready_i) st_d = S_CAS_WAIT;
      S_CAS_WAIT: if (mrsp_valid_i) begin
        if (mrsp_ok_i) begin
          adv = 1'b1;
        end else if (ev_leaf) begin
          st_d     = S_RD_REQ;
          lvl_d    = 2'd3;
          base_d   = root_q;
          perm_clr = 1'b1;
        end else begin
          st_d = S_RD_REQ;
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (adv) begin
      if (ev_leaf) begin
        pa_d = leaf_pa;
        sz_d = ev_size;
        st_d = S_DONE;
      end else begin
        base_d = ent_sel[PA_W-1:12];
        lvl_d  = lvl_q - 2'd1;
        st_d   = S_RD_REQ;
      end
    end
  end
  assign perm_acc = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      lvl_q   <= 2'd0;
      base_q  <= '0;
      root_q  <= '0;
      va_q    <= '0;
      ent_q   <= '0;
      store_q <= 1'b0;
      nxen_q  <= 1'b0;
      fk_q    <= FK_NONE;
      sz_q    <= SZ_4K;
      pa_q    <= '0;
    end else begin
      st_q   <= st_d;
      lvl_q  <= lvl_d;
      base_q <= base_d;
      ent_q  <= ent_d;
      fk_q   <= fk_d;
      sz_q   <= sz_d;
      pa_q   <= pa_d;
      if (take) begin
        root_q  <= root_i[PA_W-1:12];
        va_q    <= vaddr_i;
        store_q <= store_i;
        nxen_q  <= nx_en_i;
      end
    end
  end

  assign busy_o       = (st_q != S_IDLE);
  assign done_o       = (st_q == S_DONE);
  assign fault_kind_o = fk_q;
  assign paddr_o      = pa_q;
  assign page_size_o  = sz_q;
  assign mreq_valid_o = (st_q == S_RD_REQ) || (st_q == S_CAS_REQ);
  assign mreq_cas_o   = (st_q == S_CAS_REQ);
  assign mreq_addr_o  = {base_q, idx, 3'b000};
  assign mreq_cmp_o   = ent_q[31:0];
  assign mreq_swap_o  = ent_q[31:0] | set_bits;
  assign unused_root  = ^{root_i[63:PA_W], root_i[11:0]};
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int PA_W = 46
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy_o,
  input logic            done_o,
  input logic            mreq_valid_o,
  input logic            mreq_ready_i,
  input logic            mreq_cas_o,
  input logic [PA_W-1:0] mreq_addr_o,
  input logic [31:0]     mreq_cmp_o,
  input logic [31:0]     mreq_swap_o
);
  // R10: a stalled request keeps its fields
  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid_o && !mreq_ready_i |=> mreq_valid_o && $stable(mreq_addr_o) && $stable(mreq_cas_o));

  // R1: entry addresses are 8-byte aligned
  p_entry_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid_o |-> (mreq_addr_o[2:0] == 3'b000));

  // R6 / R7: a swap only adds accessed/dirty bits, and is never a no-op
  p_swap_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid_o && mreq_cas_o |->
      ((mreq_swap_o & mreq_cmp_o) == mreq_cmp_o) && (mreq_swap_o != mreq_cmp_o) &&
      (((mreq_swap_o ^ mreq_cmp_o) & ~32'h0000_0060) == 32'd0));

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11: no memory traffic while idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mreq_valid_o);
endmodule

bind pt_walker pw_checker #(.PA_W(PA_W)) i_pw_checker (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .mreq_valid_o(mreq_valid_o), .mreq_ready_i(mreq_ready_i), .mreq_cas_o(mreq_cas_o),
  .mreq_addr_o(mreq_addr_o), .mreq_cmp_o(mreq_cmp_o), .mreq_swap_o(mreq_swap_o)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  localparam int PA_W = 36;
  localparam logic [63:0] P  = 64'h1, RW = 64'h2, U = 64'h4, A = 64'h20, D = 64'h40, PS = 64'h80;
  localparam logic [63:0] NX = 64'h8000_0000_0000_0000;

  typedef struct {
    bit          cas;
    bit          leaf;
    logic [63:0] addr;
    logic [31:0] cmp;
    logic [31:0] swp;
  } req_t;

  typedef struct {
    logic [1:0]  fk;
    logic [63:0] pa;
    logic [1:0]  sz;
    bit          u, w, x;
  } res_t;

  logic clk = 1'b0;
  logic rst_n;
  logic start, nx_en, store;
  logic [47:0] vaddr;
  logic [63:0] root_r;
  logic busy_o, done_o, user_o, write_o, nx_o;
  logic [1:0] fault_kind_o, page_size_o;
  logic [PA_W-1:0] paddr_o, mreq_addr_o;
  logic mreq_valid_o, mreq_cas_o;
  logic [31:0] mreq_cmp_o, mreq_swap_o;
  logic mreq_ready, mrsp_valid, mrsp_ok;
  logic [63:0] mrsp_data;

  int errors = 0;
  int checks = 0;
  logic [63:0] mem [longint];
  req_t exp_q[$];
  int fail_at = -1;
  int cas_seen = 0;

  always #4 clk = ~clk;

  pt_walker #(.PA_W(PA_W)) i_pt_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start), .vaddr_i(vaddr), .root_i(root_r),
    .nx_en_i(nx_en), .store_i(store), .busy_o(busy_o), .done_o(done_o),
    .fault_kind_o(fault_kind_o), .paddr_o(paddr_o), .page_size_o(page_size_o),
    .user_o(user_o), .write_o(write_o), .nx_o(nx_o),
    .mreq_valid_o(mreq_valid_o), .mreq_ready_i(mreq_ready), .mreq_cas_o(mreq_cas_o),
    .mreq_addr_o(mreq_addr_o), .mreq_cmp_o(mreq_cmp_o), .mreq_swap_o(mreq_swap_o),
    .mrsp_valid_i(mrsp_valid), .mrsp_data_i(mrsp_data), .mrsp_ok_i(mrsp_ok)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(longint'(a)) ? mem[longint'(a)] : 64'd0;
  endfunction

  // Behavioural walk on a shadow copy of memory: fills exp_q and the result.
  task automatic ref_walk(input logic [47:0] va, input logic [63:0] root, input bit nx,
                          input bit st, input int fail_n, output res_t r);
    logic [63:0] sh [longint];
    logic [63:0] frm_mask, base, ad, e, hi;
    int lvl, casn;
    bit fin, bad, lf;
    logic [31:0] setb;
    sh = mem;
    frm_mask = ((64'd1 << PA_W) - 1) & ~64'hfff;
    casn = 0;
    fin = 0;
    r.fk = 0; r.pa = 0; r.sz = 0;
    while (!fin) begin
      base = root & frm_mask; lvl = 3; r.u = 1; r.w = 1; r.x = 0;
      while (!fin) begin
        ad = (base & frm_mask) + 64'(((va >> (12 + 9 * lvl)) & 48'h1ff) * 8);
        e = sh.exists(longint'(ad)) ? sh[longint'(ad)] : 64'd0;
        exp_q.push_back('{cas: 0, leaf: 0, addr: ad, cmp: 0, swp: 0});
        if (!e[0]) begin r.fk = 1; fin = 1; break; end
        hi = (e >> PA_W) & ((64'd1 << (52 - PA_W)) - 1);
        lf = (lvl == 0) || (e[7] && (lvl == 1 || lvl == 2));
        bad = (hi != 0) || (!nx && e[63]) || (lvl == 3 && e[7]) ||
              (lf && lvl == 2 && ((e >> 13) & 64'h1ffff) != 0) ||
              (lf && lvl == 1 && ((e >> 13) & 64'hff) != 0);
        if (bad) begin r.fk = 2; fin = 1; break; end
        setb = 32'h20 | ((lf && st) ? 32'h40 : 32'h0);
        if ((setb & ~e[31:0]) != 0) begin
          exp_q.push_back('{cas: 1, leaf: lf, addr: ad, cmp: e[31:0], swp: e[31:0] | setb});
          if (casn++ == fail_n) begin
            if (lf) break;
            continue;
          end
          e[31:0] = e[31:0] | setb;
          sh[longint'(ad)] = e;
        end
        r.u = r.u & e[2]; r.w = r.w & e[1]; r.x = r.x | e[63];
        if (lf) begin
          r.sz = (lvl == 2) ? 2'd2 : (lvl == 1) ? 2'd1 : 2'd0;
          if (lvl == 2)      r.pa = (e & frm_mask & ~64'h3fff_ffff) | 64'(va & 48'h3fff_ffff);
          else if (lvl == 1) r.pa = (e & frm_mask & ~64'h1f_ffff)   | 64'(va & 48'h1f_ffff);
          else               r.pa = (e & frm_mask) | 64'(va & 48'hfff);
          fin = 1;
        end else begin
          base = e;
          lvl--;
        end
      end
    end
  endtask

  // Memory responder: one outstanding request, stalls and variable latency.
  initial begin : responder
    bit pend = 0;
    int dly = 0, cyc = 0;
    logic [63:0] pdata;
    bit pok;
    req_t x;
    mreq_ready = 0; mrsp_valid = 0; mrsp_ok = 0; mrsp_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mrsp_valid = 0;
      if (pend) begin
        if (dly == 0) begin
          mrsp_valid = 1; mrsp_data = pdata; mrsp_ok = pok; pend = 0;
        end else dly--;
      end
      mreq_ready = rst_n && !pend && !mrsp_valid && (cyc % 5 != 2);
      if (mreq_valid_o && mreq_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10 unexpected request", 64'(mreq_addr_o), 0);
          pdata = 0; pok = 0;
        end else begin
          x = exp_q.pop_front();
          chk(mreq_cas_o == x.cas, x.cas ? "R6/R7 kind" : "R1 kind", 64'(mreq_cas_o), 64'(x.cas));
          chk(64'(mreq_addr_o) == x.addr, "R1 address", 64'(mreq_addr_o), x.addr);
          if (x.cas) begin
            chk(mreq_cmp_o == x.cmp, x.leaf ? "R7 cmp" : "R6 cmp", 64'(mreq_cmp_o), 64'(x.cmp));
            chk(mreq_swap_o == x.swp, x.leaf ? "R7 swap" : "R6 swap", 64'(mreq_swap_o), 64'(x.swp));
          end
          if (mreq_cas_o) begin
            pok = (cas_seen != fail_at) && (rd(64'(mreq_addr_o)) & 64'hffff_ffff) == 64'(mreq_cmp_o);
            cas_seen++;
            if (pok) mem[longint'(mreq_addr_o)] = {rd(64'(mreq_addr_o))[63:32], mreq_swap_o};
            pdata = 0;
          end else begin
            pdata = rd(64'(mreq_addr_o)); pok = 0;
          end
        end
        pend = 1; dly = cyc % 3;
      end
    end
  end

  task automatic run(input string tg, input logic [47:0] va, input logic [63:0] root,
                     input bit nx, input bit st, input int fail_n, input bit extra);
    res_t e;
    int n;
    exp_q.delete();
    ref_walk(va, root, nx, st, fail_n, e);
    fail_at = fail_n; cas_seen = 0;
    @(negedge clk);
    vaddr = va; root_r = root; nx_en = nx; store = st; start = 1;
    @(negedge clk);
    start = 0;
    if (extra) begin
      repeat (2) @(negedge clk);
      vaddr = va ^ 48'h4000_0000_0000; store = !st; start = 1;
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while (!done_o && n < 3000) begin @(negedge clk); n++; end
    chk(done_o, {tg, " done reached"}, 64'(done_o), 1);
    chk(fault_kind_o == e.fk, {tg, " fault kind"}, 64'(fault_kind_o), 64'(e.fk));
    if (e.fk == 0) begin
      chk(64'(paddr_o) == e.pa, {tg, " R9 paddr"}, 64'(paddr_o), e.pa);
      chk(page_size_o == e.sz, {tg, " R4 page size"}, 64'(page_size_o), 64'(e.sz));
      chk({user_o, write_o, nx_o} == {e.u, e.w, e.x}, {tg, " R8 perms"},
          64'({user_o, write_o, nx_o}), 64'({e.u, e.w, e.x}));
    end
    chk(exp_q.size() == 0, {tg, " R10 all requests seen"}, 64'(exp_q.size()), 0);
    @(negedge clk);
    chk(!done_o && !busy_o, {tg, " R11 single done pulse"}, 64'({done_o, busy_o}), 0);
    repeat (3) @(negedge clk);
    chk(!done_o && !busy_o && !mreq_valid_o, {tg, " R11 stays idle"},
        64'({done_o, busy_o, mreq_valid_o}), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired (R11) actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    rst_n = 0; start = 0; nx_en = 0; store = 0; vaddr = '0; root_r = '0;
    // four-level path
    mem[longint'(64'h1008)] = 64'h2000 | P | RW | U;
    mem[longint'(64'h2010)] = 64'h3000 | P | RW | U;
    mem[longint'(64'h3018)] = 64'h4000 | P | RW | NX;
    mem[longint'(64'h4020)] = 64'h1_2345_6000 | P | RW | U;
    mem[longint'(64'h4040)] = 64'h5000 | RW;
    // 2 MB leaves
    mem[longint'(64'h3028)] = 64'h4060_0000 | 64'h1000 | P | U | PS | A | D;
    mem[longint'(64'h3030)] = 64'h4060_2000 | P | PS;
    // 1 GB leaves
    mem[longint'(64'h2048)] = 64'h4000_0000 | P | RW | U | PS;
    mem[longint'(64'h2050)] = 64'h4200_0000 | P | PS;
    // reserved at top level
    mem[longint'(64'h1010)] = 64'h2000 | P | PS;
    mem[longint'(64'h1018)] = (64'd1 << 40) | 64'h2000 | P;
    // fresh path for swap-failure cases
    mem[longint'(64'h1028)] = 64'h6000 | P | RW | U;
    mem[longint'(64'h6000)] = 64'h7000 | P | RW | U;
    mem[longint'(64'h7000)] = 64'h8000 | P | RW | U;
    mem[longint'(64'h8000)] = 64'h9000 | P | RW | U;
    mem[longint'(64'h8008)] = 64'hA000 | P | RW | U;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !mreq_valid_o, "R11 reset state",
        64'({busy_o, done_o, mreq_valid_o}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o && !mreq_valid_o, "R11 idle after reset",
        64'({busy_o, done_o, mreq_valid_o}), 0);

    run("R6 R8 4K load, accessed set at every level", {9'd1, 9'd2, 9'd3, 9'd4, 12'habc}, 64'h1abc, 1, 0, -1, 0);
    run("R7 4K store sets dirty only at leaf",        {9'd1, 9'd2, 9'd3, 9'd4, 12'h010}, 64'h1000, 1, 1, -1, 0);
    run("R7 4K store with bits already set",          {9'd1, 9'd2, 9'd3, 9'd4, 12'hfff}, 64'h1000, 1, 1, -1, 0);
    run("R3 no-execute bit while disabled",           {9'd1, 9'd2, 9'd3, 9'd4, 12'h000}, 64'h1000, 0, 0, -1, 0);
    run("R4 R5 2 MB leaf with bit 12 set",            {9'd1, 9'd2, 9'd5, 9'd7, 12'h123}, 64'h1000, 1, 0, -1, 0);
    run("R5 2 MB leaf misaligned",                    {9'd1, 9'd2, 9'd6, 9'd7, 12'h123}, 64'h1000, 1, 0, -1, 0);
    run("R4 1 GB leaf",                               {9'd1, 9'd9, 9'd3, 9'd4, 12'h055}, 64'h1000, 1, 1, -1, 0);
    run("R5 1 GB leaf misaligned",                    {9'd1, 9'd10, 9'd3, 9'd4, 12'h055}, 64'h1000, 1, 0, -1, 0);
    run("R3 large bit at top level",                  {9'd2, 9'd0, 9'd0, 9'd0, 12'h000}, 64'h1000, 1, 0, -1, 0);
    run("R3 address above physical width",            {9'd3, 9'd0, 9'd0, 9'd0, 12'h000}, 64'h1000, 1, 0, -1, 0);
    run("R2 leaf not present",                        {9'd1, 9'd2, 9'd3, 9'd8, 12'h000}, 64'h1000, 1, 0, -1, 0);
    run("R2 top entry not present",                   {9'd4, 9'd0, 9'd0, 9'd0, 12'h000}, 64'h1000, 1, 0, -1, 0);
    run("R6 failed swap re-reads the entry",          {9'd5, 9'd0, 9'd0, 9'd0, 12'h0ff}, 64'h1000, 1, 0, 1, 0);
    run("R7 failed leaf swap restarts from root",     {9'd5, 9'd0, 9'd0, 9'd1, 12'h001}, 64'h1000, 1, 1, 0, 0);
    run("R11 start while busy ignored",               {9'd1, 9'd2, 9'd3, 9'd4, 12'h321}, 64'h1000, 1, 0, -1, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule